// File: doc/BRIEF.md
# Two-Stage Serial Bit-Clock Generator

This block produces the serial clock for a synchronous serial port from the fast peripheral clock. Two dividers are chained. The first is an even prescaler. The second is a rate divider that divides by one plus an 8-bit rate value. Together they set the half-period of the serial clock. The block drives the serial clock level with the chosen idle polarity. Alongside it, the block issues one-cycle strobes that tell a neighbouring shift engine when to sample incoming data, when to launch the next bit, and when a bit has ended.

The generator runs only while the frame logic holds `run_i` high. While it is idle, both counters are held at zero and the clock rests at its idle level. On the clock edge that first sees `run_i` high, the prescale value, the rate value, the polarity and the phase are captured. They stay frozen until the frame ends, so reprogramming during a frame takes effect at the next frame. Dropping `run_i` ends the frame, and the clock returns to its idle level. There is no data path through the block, so it has no handshake; every pin is plain control or status.

Top module: `sclk_divgen`

## Requirements
- R1: With effective prescale P and rate value S, `sclk_o` toggles every H = (P/2)*(1+S) clock cycles while a frame runs, so one bit lasts P*(1+S) cycles.
- R2: The effective prescale P is `psc_i` with bit 0 forced to zero, and a resulting value of 0 is treated as 2 (for example 7 acts as 6 and 0 or 1 act as 2).
- R3: Let E0 be the clock edge that first samples `run_i` high while idle. The first toggle of `sclk_o` happens exactly H cycles after E0.
- R4: While no frame runs, `sclk_o` equals `cpol_i` (registered, one cycle later), and `edge_o`, `sample_o`, `shift_o` and `bit_o` are all low. On the edge that samples `run_i` low, `sclk_o` returns to the frame's polarity.
- R5: `edge_o` is high for exactly the one cycle that precedes each toggle of `sclk_o`, and at no other time.
- R6: Edges of a frame are numbered from 0. Even-numbered edges are leading edges and odd-numbered edges are trailing edges. With `cpha_i`=0, `sample_o` marks leading edges and `shift_o` marks trailing edges. With `cpha_i`=1 the roles swap. The two strobes are never high together.
- R7: `bit_o` pulses together with `edge_o` on every trailing edge, which marks the end of each bit.
- R8: Prescale, rate, polarity and phase are captured at E0. Changes to these inputs during a frame have no effect on that frame, and they apply to the next frame.
- R9: The extreme settings work. P=2 with S=0 gives H=1, so `sclk_o` runs at half the input clock. P=254 with S=255 gives H=32512.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Frame active request from the frame logic |
| psc_i | input | 8 | Prescale value, even; bit 0 ignored |
| scr_i | input | 8 | Rate value S; divides by 1+S |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | 0: sample on leading edges, 1: sample on trailing edges |
| sclk_o | output | 1 | Serial clock level |
| edge_o | output | 1 | Strobe in the cycle before each serial clock toggle |
| bit_o | output | 1 | Strobe on each trailing edge (end of bit) |
| sample_o | output | 1 | Strobe on edges where received data is sampled |
| shift_o | output | 1 | Strobe on edges where the next bit is launched |

## Verification
Several corner cases are targeted. The fastest setting, H=1, would expose an off-by-one in the counter terminal: the clock would stretch to two cycles per half-period, or it would stall. Odd and zero prescale values would catch a decoder that keeps bit 0 or lets 0 divide by zero, because either mistake shifts the measured half-period. Inputs are rewritten in the middle of a frame to catch a generator that reads the live registers, since that would change the spacing and polarity partway through. Each frame's first toggle is timed against E0 to catch counters that are not cleared while idle. The sample and shift strobes are compared per edge in both phases to catch swapped roles.

// File: rtl/sclk_divgen_pkg.sv
package sclk_divgen_pkg;

  typedef struct packed {
    logic cpol;
    logic cpha;
  } spi_mode_t;

  // True when an edge with the given lead/trail position is a sampling edge.
  function automatic logic is_sample_edge(input logic cpha, input logic leading);
    return cpha ? !leading : leading;
  endfunction

endpackage

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold
  import sclk_divgen_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int SCR_W = 8,
  localparam int HW = PSC_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [SCR_W-1:0] scr_i,
  input  spi_mode_t        mode_i,
  output logic             active_o,
  output logic [HW-1:0]    half_m1_o,
  output logic [SCR_W-1:0] scr_o,
  output spi_mode_t        mode_o
);

  logic [HW-1:0] half_raw;
  logic [HW-1:0] half_m1_d;

  // bit 0 of the prescale is dropped; a zero prescale acts as two
  assign half_raw  = psc_i[PSC_W-1:1];
  assign half_m1_d = (half_raw == '0) ? '0 : half_raw - HW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o  <= 1'b0;
      half_m1_o <= '0;
      scr_o     <= '0;
      mode_o    <= '0;
    end else begin
      active_o <= run_i;
      if (!active_o) begin
        half_m1_o <= half_m1_d;
        scr_o     <= scr_i;
        mode_o    <= mode_i;
      end
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && $past(active_o)) |->
      (half_m1_o == $past(half_m1_o) && scr_o == $past(scr_o) && mode_o == $past(mode_o))) // R8
    else $error("configuration changed inside a frame");

endmodule

// File: rtl/sclk_stage_cnt.sv
module sclk_stage_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         adv_i,
  input  logic [W-1:0] limit_i,
  output logic         wrap_o
);

  logic [W-1:0] cnt_q;

  assign wrap_o = en_i && adv_i && (cnt_q == limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (adv_i)   cnt_q <= cnt_q + W'(1);
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (cnt_q <= limit_i)) // R1
    else $error("stage counter past its limit");

  AST_CNT_CLEARED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0)) // R3
    else $error("stage counter not cleared while idle");

endmodule

// File: rtl/sclk_phase.sv
module sclk_phase
  import sclk_divgen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic edge_i,
  input  logic idle_lvl_i,
  input  logic cpha_i,
  output logic sclk_o,
  output logic sample_o,
  output logic shift_o,
  output logic bit_o
);

  logic lead_q;
  logic smp_edge;

  assign smp_edge = is_sample_edge(cpha_i, lead_q);
  assign sample_o = edge_i && smp_edge;
  assign shift_o  = edge_i && !smp_edge;
  assign bit_o    = edge_i && !lead_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_o <= 1'b0;
      lead_q <= 1'b1;
    end else if (!en_i) begin
      sclk_o <= idle_lvl_i;
      lead_q <= 1'b1;
    end else if (edge_i) begin
      sclk_o <= !sclk_o;
      lead_q <= !lead_q;
    end
  end

  AST_SCLK_MOVES_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_i) && !$past(edge_i)) |-> (sclk_o == $past(sclk_o))) // R5
    else $error("serial clock moved without an edge strobe");

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_o && shift_o)) // R6
    else $error("sample and shift strobes together");

  AST_BIT_ON_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
    bit_o |=> (lead_q && sclk_o != $past(sclk_o))) // R7
    else $error("bit strobe not on a trailing edge");

endmodule

// File: rtl/sclk_divgen.sv
module sclk_divgen
  import sclk_divgen_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int SCR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [SCR_W-1:0] scr_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  output logic             sclk_o,
  output logic             edge_o,
  output logic             bit_o,
  output logic             sample_o,
  output logic             shift_o
);

  localparam int HW = PSC_W - 1;

  logic             active;
  logic [HW-1:0]    half_m1;
  logic [SCR_W-1:0] scr_hold;
  spi_mode_t        mode_in;
  spi_mode_t        mode_hold;
  logic             run_en;
  logic             pre_wrap;
  logic             idle_lvl;

  assign mode_in = '{cpol: cpol_i, cpha: cpha_i};

  sclk_cfg_hold #(.PSC_W(PSC_W), .SCR_W(SCR_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run_i),
    .psc_i    (psc_i),
    .scr_i    (scr_i),
    .mode_i   (mode_in),
    .active_o (active),
    .half_m1_o(half_m1),
    .scr_o    (scr_hold),
    .mode_o   (mode_hold)
  );

  assign run_en   = active && run_i;
  assign idle_lvl = active ? mode_hold.cpol : cpol_i;

  // stage 1: prescaler, half of the even prescale per half-period unit
  sclk_stage_cnt #(.W(HW)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (run_en),
    .adv_i  (1'b1),
    .limit_i(half_m1),
    .wrap_o (pre_wrap)
  );

  // stage 2: rate divider, 1 + rate value prescaler wraps per half-period
  sclk_stage_cnt #(.W(SCR_W)) u_rate (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (run_en),
    .adv_i  (pre_wrap),
    .limit_i(scr_hold),
    .wrap_o (edge_o)
  );

  sclk_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (run_en),
    .edge_i    (edge_o),
    .idle_lvl_i(idle_lvl),
    .cpha_i    (mode_hold.cpha),
    .sclk_o    (sclk_o),
    .sample_o  (sample_o),
    .shift_o   (shift_o),
    .bit_o     (bit_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !(edge_o || sample_o || shift_o || bit_o)) // R4
    else $error("strobe while idle");

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!active) |-> (sclk_o == $past(cpol_i))) // R4
    else $error("idle level does not follow polarity");

endmodule

// File: tb/sclk_divgen_bench.sv
module sclk_divgen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_i = 1'b0;
  logic [7:0] psc_i = 8'd2;
  logic [7:0] scr_i = 8'd0;
  logic       cpol_i = 1'b0;
  logic       cpha_i = 1'b0;
  logic       sclk_o, edge_o, bit_o, sample_o, shift_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = !clk;

  sclk_divgen u_sclk_divgen (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .psc_i(psc_i), .scr_i(scr_i),
    .cpol_i(cpol_i), .cpha_i(cpha_i), .sclk_o(sclk_o), .edge_o(edge_o),
    .bit_o(bit_o), .sample_o(sample_o), .shift_o(shift_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int half_period(input int psc, input int scr);
    int p;
    p = psc & 'hFE;
    if (p == 0) p = 2;
    return (p / 2) * (scr + 1);
  endfunction

  // One frame: run_i rises, len cycles observed, then run_i drops.
  task automatic run_frame(input string tag, input int psc, input int scr,
                           input bit pol, input bit pha, input int len, input bit chg);
    int h;
    h = half_period(psc, scr);
    @(negedge clk);
    psc_i = psc[7:0]; scr_i = scr[7:0]; cpol_i = pol; cpha_i = pha; run_i = 1'b1;
    for (int n = 1; n <= len; n++) begin
      int  c, k;
      bit  e, lead, smp;
      @(negedge clk);
      c    = n - 1;
      k    = c / h;
      e    = ((c % h) == h - 1);
      lead = ((k % 2) == 0);
      smp  = pha ? !lead : lead;
      check(sclk_o == (pol ^ k[0]), (c <= h) ? "R3" : tag, "sclk level",
            int'(sclk_o), int'(pol ^ k[0]));
      check(edge_o == e, "R5", "edge strobe", int'(edge_o), int'(e));
      check(sample_o == (e && smp), "R6", "sample strobe", int'(sample_o), int'(e && smp));
      check(shift_o == (e && !smp), "R6", "shift strobe", int'(shift_o), int'(e && !smp));
      check(bit_o == (e && !lead), "R7", "bit strobe", int'(bit_o), int'(e && !lead));
      if (chg && n == len / 2) begin
        // R8: rewrite every setting mid-frame
        psc_i = 8'(psc + 6); scr_i = 8'(scr + 3); cpol_i = !pol; cpha_i = !pha;
      end
    end
    run_i  = 1'b0;
    cpol_i = pol;
    @(negedge clk);
    check(sclk_o == pol, "R4", "level after frame end", int'(sclk_o), int'(pol));
    check(edge_o == 1'b0, "R4", "edge after frame end", int'(edge_o), 0);
  endtask

  task automatic test_reset();
    check(sclk_o == 1'b0, "R4", "reset sclk", int'(sclk_o), 0);
    check({edge_o, bit_o, sample_o, shift_o} == 4'b0, "R4", "reset strobes",
          int'({edge_o, bit_o, sample_o, shift_o}), 0);
  endtask

  task automatic test_idle();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cpol_i = i[0];
      @(negedge clk);
      check(sclk_o == i[0], "R4", "idle level follows polarity", int'(sclk_o), i);
      check({edge_o, sample_o, shift_o, bit_o} == 4'b0, "R4", "idle strobes",
            int'({edge_o, sample_o, shift_o, bit_o}), 0);
    end
    cpol_i = 1'b0;
  endtask

  task automatic test_fastest();   run_frame("R9", 2, 0, 1'b0, 1'b0, 12, 1'b0); endtask
  task automatic test_mode3();     run_frame("R1", 6, 2, 1'b1, 1'b1, 60, 1'b0); endtask
  task automatic test_mode1();     run_frame("R1", 4, 1, 1'b0, 1'b1, 40, 1'b0); endtask
  task automatic test_odd_psc();   run_frame("R2", 7, 0, 1'b0, 1'b0, 20, 1'b0); endtask
  task automatic test_zero_psc();  run_frame("R2", 0, 3, 1'b1, 1'b0, 20, 1'b0); endtask
  task automatic test_one_psc();   run_frame("R2", 1, 1, 1'b0, 1'b1, 10, 1'b0); endtask

  task automatic test_midframe();
    run_frame("R8", 4, 1, 1'b0, 1'b0, 40, 1'b1);
    // new values (10, 4) apply only to the next frame
    run_frame("R8", 10, 4, 1'b1, 1'b0, 60, 1'b0);
  endtask

  task automatic test_abort();
    // frame cut mid half-period; next frame must restart from zero (R3)
    run_frame("R3", 10, 2, 1'b0, 1'b0, 7, 1'b0);
    run_frame("R3", 10, 2, 1'b0, 1'b0, 20, 1'b0);
  endtask

  task automatic test_slowest();   run_frame("R9", 254, 255, 1'b0, 1'b1, 2 * 32512 + 2, 1'b0); endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_idle();
    test_fastest();
    test_mode3();
    test_mode1();
    test_odd_psc();
    test_zero_psc();
    test_one_psc();
    test_midframe();
    test_abort();
    test_slowest();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule